// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Emulator

This block is a synthesizable stand-in for a one-bit-wide dynamic memory with a time-multiplexed address bus. It gives a memory controller under test a target that behaves like the device at its pins. A falling row strobe latches the row half of the cell index. A later falling column strobe latches the column half, and the write-enable level at that moment selects a read or an early write. The model stores bits in an internal array. It drives its data output with an output-enable that stands in for the three-state pin.

All strobes are sampled on the system clock, and edges are found by comparing each sample with the one taken at the previous edge. The output-enable rules depend on the order of the write-enable and the column strobe. In an early write the output is never driven. In a read, or a read followed by a late write, the output turns on a fixed number of clocks after the column strobe falls. It stays on until the column strobe rises, even if the row strobe has already risen. A row-strobe pulse with no column strobe is a refresh of the latched row. The model keeps an age counter for every row and raises an error flag while any row has gone too long without one.

Top module: `dram_emu`

## Requirements
- R1: The address sampled at the clock edge that first sees RAS_n low is the row. The address sampled at the edge that first sees CAS_n low while a row is held is the column. The cell index is {row, col}, with the row in the upper half.
- R2: A read returns on q the bit last written to the addressed cell.
- R3: After reset, q_oe and refresh_err are 0. Any clock edge that samples cas_n high leaves q_oe at 0 after that edge.
- R4: In a read (w_n sampled high at the edge that detects CAS_n falling), q_oe is 0 for the first ACCESS_DLY edges of the CAS_n-low period, counting the detecting edge. It is set at edge ACCESS_DLY+1.
- R5: If w_n is sampled low at the edge that detects CAS_n falling (early write), the bit d sampled at that edge is written to the cell. q_oe stays 0 until CAS_n rises.
- R6: If w_n falls during a read (late write), q stays driven with the cell's previous contents. The cell takes the d sampled at the edge that detects w_n falling.
- R7: Once q_oe is 1 it stays 1, with q unchanged, when RAS_n rises. It is cleared only by CAS_n rising.
- R8: A RAS_n low period with no accepted CAS_n fall is a refresh of the latched row. The refresh happens on the edge that detects RAS_n rising. q_oe stays 0, and no cell changes.
- R9: Every row has an age that counts clock cycles since its last refresh, or since reset. refresh_err is 1 exactly while some row's age has reached REFRESH_LIMIT. It drops to 0 once every overdue row has been refreshed.
- R10: A CAS_n fall while RAS_n is high starts no access. q_oe stays 0 and no cell is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Multiplexed row/column address |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| w_n | input | 1 | Write enable, active low |
| d | input | 1 | Write data |
| q | output | 1 | Read data, meaningful while q_oe is 1 |
| q_oe | output | 1 | Output drive enable (0 = high impedance) |
| refresh_err | output | 1 | Some row is overdue for refresh |

## Verification
The bench builds the block with ADDR_W = 3, ACCESS_DLY = 2 and REFRESH_LIMIT = 300. The array then holds 64 cells and has 8 rows. With this size the bench can write every cell with an early write, read every cell back, and invert every cell with a late write. An asymmetric pattern computed from the index exposes any mix-up between row and column. The short refresh limit lets the bench watch rows go overdue and recover. It also isolates a single stale row, while the access-window edges are checked cycle by cycle.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE     = 2'd0,
        CYC_READ     = 2'd1,
        CYC_EARLY_WR = 2'd2,
        CYC_READ_WR  = 2'd3
    } cyc_mode_e;

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);

    logic [N-1:0] prev_d, prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb prev_d[g] = lvl[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_idx] <= wr_bit;
    end

    assign rd_bit = cells_q[rd_idx];

endmodule

// File: rtl/dram_refresh_tracker.sv
module dram_refresh_tracker #(
    parameter int ROW_IDX_W = 5,
    parameter int LIMIT     = 4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_pulse,
    input  logic [ROW_IDX_W-1:0] refresh_row,
    output logic                 overdue
);

    localparam int ROWS  = 1 << ROW_IDX_W;
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [ROWS-1:0] late;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [CNT_W-1:0] age_d, age_q;

        always_comb begin
            if (refresh_pulse && refresh_row == ROW_IDX_W'(g))
                age_d = '0;
            else if (age_q == CNT_W'(LIMIT))
                age_d = age_q;
            else
                age_d = age_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) age_q <= '0;
            else        age_q <= age_d;
        end

        assign late[g] = (age_q == CNT_W'(LIMIT));
    end

    assign overdue = |late;

endmodule

// File: rtl/dram_emu.sv
module dram_emu
    import dram_emu_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int ACCESS_DLY    = 3,
    parameter int REFRESH_LIMIT = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              w_n,
    input  logic              d,
    output logic              q,
    output logic              q_oe,
    output logic              refresh_err
);

    localparam int CELL_W = 2 * ADDR_W;
    localparam int DLY_W  = $clog2(ACCESS_DLY + 1) + 1;

    typedef struct packed {
        logic              ras_active;
        logic              cas_seen;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        cyc_mode_e         mode;
        logic [DLY_W-1:0]  dly;
        logic              q;
        logic              oe;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]        strobe_prev;
    logic              ras_fall, ras_rise, cas_fall, cas_rise, w_fall;
    logic              wr_en, wr_bit, rd_bit;
    logic [CELL_W-1:0] wr_idx, rd_idx;
    logic              refresh_pulse;

    dram_strobe_sampler #(.N(3)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({w_n, cas_n, ras_n}),
        .prev  (strobe_prev)
    );

    assign ras_fall = strobe_prev[0] & ~ras_n;
    assign ras_rise = ~strobe_prev[0] & ras_n;
    assign cas_fall = strobe_prev[1] & ~cas_n;
    assign cas_rise = ~strobe_prev[1] & cas_n;
    assign w_fall   = strobe_prev[2] & ~w_n;

    assign rd_idx = {st_q.row, st_q.col};

    always_comb begin
        st_d          = st_q;
        wr_en         = 1'b0;
        wr_idx        = rd_idx;
        wr_bit        = d;
        refresh_pulse = 1'b0;

        // row latch
        if (ras_fall) begin
            st_d.ras_active = 1'b1;
            st_d.cas_seen   = 1'b0;
            st_d.row        = addr;
        end

        // column latch and cycle-type decision
        if (cas_fall && st_q.ras_active && !ras_n) begin
            st_d.cas_seen = 1'b1;
            st_d.col      = addr;
            if (!w_n) begin
                st_d.mode = CYC_EARLY_WR;
                wr_en     = 1'b1;
                wr_idx    = {st_q.row, addr};
            end else begin
                st_d.mode = CYC_READ;
                st_d.dly  = DLY_W'(ACCESS_DLY);
            end
        end

        // late write inside a read cycle
        if (st_q.mode == CYC_READ && w_fall) begin
            st_d.mode = CYC_READ_WR;
            wr_en     = 1'b1;
            wr_idx    = rd_idx;
        end

        // access delay countdown
        if ((st_q.mode == CYC_READ || st_q.mode == CYC_READ_WR) && st_q.dly != '0) begin
            if (st_q.dly == DLY_W'(1)) begin
                st_d.oe  = 1'b1;
                st_d.q   = rd_bit;
                st_d.dly = '0;
            end else begin
                st_d.dly = st_q.dly - 1'b1;
            end
        end

        // row release: refresh when no column was taken
        if (ras_rise && st_q.ras_active) begin
            refresh_pulse   = ~st_q.cas_seen;
            st_d.ras_active = 1'b0;
        end

        // column release ends the data phase
        if (cas_rise) begin
            st_d.mode = CYC_IDLE;
            st_d.dly  = '0;
            st_d.oe   = 1'b0;
            st_d.q    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ras_active: 1'b0, cas_seen: 1'b0, row: '0, col: '0,
                      mode: CYC_IDLE, dly: '0, q: 1'b0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    dram_cell_array #(.IDX_W(CELL_W)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (wr_bit),
        .rd_idx (rd_idx),
        .rd_bit (rd_bit)
    );

    dram_refresh_tracker #(
        .ROW_IDX_W (ADDR_W),
        .LIMIT     (REFRESH_LIMIT)
    ) u_refresh (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_pulse (refresh_pulse),
        .refresh_row   (st_q.row),
        .overdue       (refresh_err)
    );

    assign q    = st_q.q;
    assign q_oe = st_q.oe;

endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk #(
    parameter int ACCESS_DLY = 3
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic w_n,
    input logic q_oe,
    input logic refresh_err
);

    localparam int LC_W = $clog2(ACCESS_DLY + 3) + 1;

    logic            cas_prev_q, ras_prev_q, early_q;
    logic [LC_W-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_prev_q <= 1'b1;
            ras_prev_q <= 1'b1;
            early_q    <= 1'b0;
            low_cnt_q  <= '0;
        end else begin
            cas_prev_q <= cas_n;
            ras_prev_q <= ras_n;
            if (cas_n)
                early_q <= 1'b0;
            else if (cas_prev_q && !w_n && !ras_n && !ras_prev_q)
                early_q <= 1'b1;
            if (cas_n)
                low_cnt_q <= '0;
            else if (low_cnt_q != '1)
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // R3: a high column strobe turns the output off at that edge
    assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |=> !q_oe);

    // R4: the output turns on exactly after the access window
    assert_access_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_oe) |-> (low_cnt_q == LC_W'(ACCESS_DLY + 1)));

    // R5: an early write never drives the output
    assert_early_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        early_q |-> !q_oe);

    // R9: the error only clears right after a row strobe release
    assert_err_clear_by_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_err) |-> ($past(ras_n) && !$past(ras_n, 2)));

endmodule

bind dram_emu dram_emu_chk #(.ACCESS_DLY(ACCESS_DLY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .w_n         (w_n),
    .q_oe        (q_oe),
    .refresh_err (refresh_err)
);

// File: tb/dram_emu_tb.sv
module dram_emu_tb;

    localparam int AW    = 3;
    localparam int DLY   = 2;
    localparam int LIM   = 300;
    localparam int CELLS = 1 << (2 * AW);
    localparam int ROWS  = 1 << AW;
    localparam int MASK  = ROWS - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ras_n, cas_n, w_n, d;
    logic          q, q_oe, refresh_err;

    always #5 clk = ~clk;

    dram_emu #(.ADDR_W(AW), .ACCESS_DLY(DLY), .REFRESH_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
        .w_n(w_n), .d(d), .q(q), .q_oe(q_oe), .refresh_err(refresh_err)
    );

    int checks = 0;
    int fails  = 0;
    bit model [CELLS];

    function automatic bit pat(int i);
        return bit'((((i * 5) >> 1) ^ (i >> 3) ^ i) & 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int row, input int col, input bit exp, input string req,
                      input bit ras_first);
        @(negedge clk); addr = AW'(row); ras_n = 1'b0;
        @(negedge clk); addr = AW'(col); cas_n = 1'b0;
        for (int i = 0; i < DLY; i++) begin
            @(negedge clk); chk(q_oe == 1'b0, "R4 early", q_oe, 0);
        end
        @(negedge clk);
        chk(q_oe == 1'b1, "R4 on time", q_oe, 1);
        chk(q == exp, req, q, exp);
        if (ras_first) begin
            ras_n = 1'b1;
            repeat (2) @(negedge clk);
            chk(q_oe == 1'b1, "R7 oe after RAS rise", q_oe, 1);
            chk(q == exp, "R7 data after RAS rise", q, exp);
        end
        cas_n = 1'b1; ras_n = 1'b1;
        @(negedge clk); chk(q_oe == 1'b0, "R3 off after CAS rise", q_oe, 0);
    endtask

    task automatic ew(input int row, input int col, input bit b);
        @(negedge clk); addr = AW'(row); ras_n = 1'b0;
        @(negedge clk); addr = AW'(col); w_n = 1'b0; d = b; cas_n = 1'b0;
        repeat (DLY + 2) begin
            @(negedge clk); chk(q_oe == 1'b0, "R5 quiet", q_oe, 0);
        end
        cas_n = 1'b1; ras_n = 1'b1; w_n = 1'b1;
        @(negedge clk);
        model[(row << AW) | col] = b;
    endtask

    task automatic lw(input int row, input int col, input bit nb, input bit old);
        @(negedge clk); addr = AW'(row); ras_n = 1'b0;
        @(negedge clk); addr = AW'(col); cas_n = 1'b0;
        repeat (DLY + 1) @(negedge clk);
        chk(q_oe == 1'b1, "R6 oe", q_oe, 1);
        chk(q == old, "R6 old data", q, old);
        w_n = 1'b0; d = nb;
        @(negedge clk);
        chk(q_oe == 1'b1, "R6 oe after W fall", q_oe, 1);
        chk(q == old, "R6 data after W fall", q, old);
        d = ~nb;
        @(negedge clk);
        cas_n = 1'b1; ras_n = 1'b1; w_n = 1'b1;
        @(negedge clk);
        model[(row << AW) | col] = nb;
    endtask

    task automatic refr(input int row);
        @(negedge clk); addr = AW'(row); ras_n = 1'b0;
        @(negedge clk); chk(q_oe == 1'b0, "R8 no drive", q_oe, 0);
        ras_n = 1'b1;
        @(negedge clk); chk(q_oe == 1'b0, "R8 no drive", q_oe, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; addr = '0; ras_n = 1'b1; cas_n = 1'b1; w_n = 1'b1; d = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(q_oe == 1'b0, "R3 reset oe", q_oe, 0);
        chk(refresh_err == 1'b0, "R9 reset err", refresh_err, 0);

        // R1: transposed cells hold different bits
        ew(1, 2, 1'b1);
        ew(2, 1, 1'b0);
        rd(1, 2, 1'b1, "R1 row/col order", 1'b0);
        rd(2, 1, 1'b0, "R1 row/col order", 1'b0);

        // R2: fill and read back every cell
        for (int i = 0; i < CELLS; i++) ew(i >> AW, i & MASK, pat(i));
        for (int i = 0; i < CELLS; i++)
            rd(i >> AW, i & MASK, model[i], "R2 readback", bit'((i % 8) == 0));

        chk(refresh_err == 1'b1, "R9 overdue after idle rows", refresh_err, 1);

        // R6: invert every cell with a late write
        for (int i = 0; i < CELLS; i++) lw(i >> AW, i & MASK, ~model[i], model[i]);
        for (int i = 0; i < CELLS; i++)
            rd(i >> AW, i & MASK, model[i], "R6 new data", 1'b0);

        // R10: CAS strobe with RAS high
        rd(4, 6, model[(4 << AW) | 6], "R2 readback", 1'b1);
        @(negedge clk); addr = AW'(6); w_n = 1'b0; d = ~model[(4 << AW) | 6]; cas_n = 1'b0;
        repeat (DLY + 2) begin
            @(negedge clk); chk(q_oe == 1'b0, "R10 no access", q_oe, 0);
        end
        cas_n = 1'b1; w_n = 1'b1;
        @(negedge clk);
        rd(4, 6, model[(4 << AW) | 6], "R10 cell unchanged", 1'b0);

        // R8 / R9: refresh every row
        for (int r = 0; r < ROWS; r++) refr(r);
        @(negedge clk);
        chk(refresh_err == 1'b0, "R9 cleared", refresh_err, 0);
        for (int r = 0; r < ROWS; r++)
            rd(r, (r * 3) & MASK, model[(r << AW) | ((r * 3) & MASK)], "R8 data kept", 1'b0);

        // R9: a single stale row
        repeat (150) @(negedge clk);
        for (int r = 0; r < ROWS; r++) if (r != 5) refr(r);
        repeat (160) @(negedge clk);
        chk(refresh_err == 1'b1, "R9 row 5 stale", refresh_err, 1);
        refr(5);
        @(negedge clk);
        chk(refresh_err == 1'b0, "R9 row 5 refreshed", refresh_err, 0);

        finish_run();
    end

endmodule